// File: doc/BRIEF.md
# Two-Port Hardware Lock Bank

This block holds a bank of single-bit mutual-exclusion locks shared by two processor cores. Each core has its own simple register port: a request strobe, a write-enable, a byte address and write data in; read data and a ready strobe out. Every lock sits at its own 32-bit word. Reading that word is an atomic test-and-set: the read returns a nonzero value when the caller has just taken a free lock, and zero when the lock was already held. Writing the word frees the lock. Software claims a lock by reading it until the answer is nonzero, and frees it with any write.

A separate read-only word reports the state of all locks as one bitmask. Both cores may hit the same lock in the same cycle. A fixed rule settles each collision, so at most one caller ever wins a given lock. A synchronous clear input frees every lock at once. The block does not record which core holds a lock.

Top module: `spinlock_bank`

## Requirements
- R1: With default parameters the bank has 32 locks. Lock n is at byte address 0x80 + 4*n, and only word-aligned addresses decode. The status word is at address 0x04. Any other address reads as 0 and writes to it have no effect.
- R2: A read of a free lock returns 1 and leaves the lock held.
- R3: A read of a held lock returns 0 and leaves the lock held.
- R4: A lock is not re-entrant: a core that holds a lock gets 0 when it reads that lock again.
- R5: A write to a lock's address frees that lock whatever the data value, and either core may free it.
- R6: A status read returns a mask in which bit n is 1 when lock n is held. The mask shows the state before any update made in the same cycle, and the read changes no lock.
- R7: Writes to the status address change no lock.
- R8: After rst_n is asserted (active low, asynchronous) every lock is free and both ports show ready=0 and rdata=0.
- R9: A cycle with clr_all high frees every lock. A lock read in that same cycle returns 0.
- R10: When both cores read the same free lock in one cycle, core 0 gets 1 and core 1 gets 0.
- R11: When one port writes a lock and the other reads it in the same cycle, the release is applied first, so the reader gets 1 and the lock stays held.
- R12: Each request produces ready=1 on the next cycle, with its read data valid in that cycle. A write returns rdata 0. With no request, ready is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_all | input | 1 | Synchronous release of every lock |
| c0_req | input | 1 | Core 0 access strobe |
| c0_we | input | 1 | Core 0 write (1) or read (0) |
| c0_addr | input | ADDR_W | Core 0 byte address |
| c0_wdata | input | DATA_W | Core 0 write data (ignored) |
| c0_rdata | output | DATA_W | Core 0 read data |
| c0_ready | output | 1 | Core 0 response strobe |
| c1_req | input | 1 | Core 1 access strobe |
| c1_we | input | 1 | Core 1 write (1) or read (0) |
| c1_addr | input | ADDR_W | Core 1 byte address |
| c1_wdata | input | DATA_W | Core 1 write data (ignored) |
| c1_rdata | output | DATA_W | Core 1 read data |
| c1_ready | output | 1 | Core 1 response strobe |

## Verification
The bench builds the bank with its default values: 32 locks, an 8-bit address with the lock array at 0x80 and status at 0x04, and 32-bit data. With these values the highest lock sits at the last word of the address space, so the decode of lock 31 and bit 31 of the status mask are both tested. A full-width status word can also be compared directly against the expected mask. Because the status word is exactly as wide as the lock count, no padding bits can hide an error in the mask.

// File: rtl/spinlock_bank.sv
module spinlock_bank #(
  parameter int NUM_LOCKS = 32,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter logic [ADDR_W-1:0] LOCK_BASE   = 'h80,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              c0_req,
  input  logic              c0_we,
  input  logic [ADDR_W-1:0] c0_addr,
  input  logic [DATA_W-1:0] c0_wdata,
  output logic [DATA_W-1:0] c0_rdata,
  output logic              c0_ready,
  input  logic              c1_req,
  input  logic              c1_we,
  input  logic [ADDR_W-1:0] c1_addr,
  input  logic [DATA_W-1:0] c1_wdata,
  output logic [DATA_W-1:0] c1_rdata,
  output logic              c1_ready
);
  localparam int IDX_W = $clog2(NUM_LOCKS);
  localparam logic [ADDR_W:0] LOCK_END = (ADDR_W+1)'(int'(LOCK_BASE) + 4*NUM_LOCKS);

  logic [NUM_LOCKS-1:0] held, held_nxt, freed, avail;
  logic [DATA_W-1:0]    held_ext;
  logic [1:0]           req, we, st_hit, lk_hit;
  logic [ADDR_W-1:0]    addr [2];
  logic [NUM_LOCKS-1:0] rd_sel [2];
  logic [NUM_LOCKS-1:0] wr_sel [2];
  logic [NUM_LOCKS-1:0] win [2];
  logic [DATA_W-1:0]    rdata_q [2];
  logic [1:0]           ready_q;

  assign req  = {c1_req, c0_req};
  assign we   = {c1_we, c0_we};
  assign addr[0] = c0_addr;
  assign addr[1] = c1_addr;

  always_comb begin
    held_ext = '0;
    held_ext[NUM_LOCKS-1:0] = held;
  end

  for (genvar g = 0; g < 2; g++) begin : g_port
    logic [ADDR_W-1:0] off;
    logic [IDX_W-1:0]  idx;
    assign off = addr[g] - LOCK_BASE;
    assign idx = off[IDX_W+1:2];
    assign st_hit[g] = addr[g] == STATUS_ADDR;
    assign lk_hit[g] = addr[g] >= LOCK_BASE && {1'b0, addr[g]} < LOCK_END
                       && addr[g][1:0] == 2'b00;
    assign rd_sel[g] = (req[g] && !we[g] && lk_hit[g]) ? NUM_LOCKS'(1) << idx : '0;
    assign wr_sel[g] = (req[g] &&  we[g] && lk_hit[g]) ? NUM_LOCKS'(1) << idx : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ready_q[g] <= 1'b0;
        rdata_q[g] <= '0;
      end else begin
        ready_q[g] <= req[g];
        if (req[g] && !we[g] && st_hit[g])      rdata_q[g] <= held_ext;
        else if (req[g] && !we[g] && lk_hit[g]) rdata_q[g] <= DATA_W'(|win[g]);
        else                                    rdata_q[g] <= '0;
      end
    end
  end

  assign freed  = held & ~(wr_sel[0] | wr_sel[1]);
  assign avail  = clr_all ? '0 : ~freed;
  assign win[0] = rd_sel[0] & avail;
  assign win[1] = rd_sel[1] & avail & ~rd_sel[0];
  assign held_nxt = clr_all ? '0 : freed | rd_sel[0] | rd_sel[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) held <= '0;
    else        held <= held_nxt;

  assign c0_rdata = rdata_q[0];
  assign c1_rdata = rdata_q[1];
  assign c0_ready = ready_q[0];
  assign c1_ready = ready_q[1];
endmodule

module spinlock_bank_chk #(
  parameter int NUM_LOCKS = 32,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter logic [ADDR_W-1:0] LOCK_BASE   = 'h80,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h04
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clr_all,
  input logic                 c0_req,
  input logic                 c0_we,
  input logic [ADDR_W-1:0]    c0_addr,
  input logic                 c1_req,
  input logic                 c1_we,
  input logic [ADDR_W-1:0]    c1_addr,
  input logic [DATA_W-1:0]    c0_rdata,
  input logic [DATA_W-1:0]    c1_rdata,
  input logic                 c0_ready,
  input logic                 c1_ready,
  input logic [NUM_LOCKS-1:0] held
);
  localparam int IDX_W = $clog2(NUM_LOCKS);
  logic [ADDR_W-1:0] c0_off;
  logic              c0_lkrd;
  assign c0_off  = c0_addr - LOCK_BASE;
  assign c0_lkrd = c0_req && !c0_we && c0_addr >= LOCK_BASE && c0_addr[1:0] == 2'b00
                   && int'(c0_off) < 4*NUM_LOCKS;

  // R12
  ready_c0_chk: assert property (@(posedge clk) disable iff (!rst_n) c0_req |=> c0_ready);
  // R12
  ready_c1_chk: assert property (@(posedge clk) disable iff (!rst_n) c1_req |=> c1_ready);
  // R2
  acquire_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_lkrd && !clr_all) |=> held[$past(c0_off[IDX_W+1:2])]);
  // R10
  one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_req && !c0_we && c1_req && !c1_we && c0_addr == c1_addr && c0_addr != STATUS_ADDR)
    |=> !(c0_rdata != '0 && c1_rdata != '0));
  // R9
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n) clr_all |=> held == '0);
  // R7
  status_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_req && c0_we && c0_addr == STATUS_ADDR && !c1_req && !clr_all) |=> $stable(held));
endmodule

bind spinlock_bank spinlock_bank_chk #(
  .NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .LOCK_BASE(LOCK_BASE), .STATUS_ADDR(STATUS_ADDR)
) u_chk (.*);

// File: tb/sim_spinlock_bank.sv
`timescale 1ns/1ps
module sim_spinlock_bank;
  logic clk = 0, rst_n = 0, clr_all = 0;
  logic c0_req = 0, c0_we = 0, c1_req = 0, c1_we = 0;
  logic [7:0]  c0_addr = 0, c1_addr = 0;
  logic [31:0] c0_wdata = 0, c1_wdata = 0;
  logic [31:0] c0_rdata, c1_rdata;
  logic c0_ready, c1_ready;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  spinlock_bank u0 (.*);

  // {core, we, addr, wdata, expected rdata, requirement}
  localparam int NV = 15;
  localparam logic [77:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h04, 32'h0,        32'h0,        4'd8},   // R8 status after reset
    {1'b0, 1'b0, 8'h80, 32'h0,        32'h1,        4'd2},   // R2 take lock 0
    {1'b0, 1'b0, 8'h80, 32'h0,        32'h0,        4'd4},   // R4 same core again
    {1'b1, 1'b0, 8'h80, 32'h0,        32'h0,        4'd3},   // R3 other core
    {1'b1, 1'b0, 8'hFC, 32'h0,        32'h1,        4'd1},   // R1 lock 31 at top word
    {1'b0, 1'b0, 8'h04, 32'h0,        32'h80000001, 4'd6},   // R6 mask
    {1'b1, 1'b1, 8'h04, 32'hFFFFFFFF, 32'h0,        4'd12},  // R12 write returns 0
    {1'b0, 1'b0, 8'h04, 32'h0,        32'h80000001, 4'd7},   // R7 status write ignored
    {1'b1, 1'b1, 8'h80, 32'h0,        32'h0,        4'd5},   // R5 other core frees
    {1'b0, 1'b0, 8'h04, 32'h0,        32'h80000000, 4'd5},
    {1'b0, 1'b1, 8'hFC, 32'hDEADBEEF, 32'h0,        4'd5},   // R5 data ignored
    {1'b1, 1'b0, 8'h04, 32'h0,        32'h0,        4'd5},
    {1'b1, 1'b0, 8'h94, 32'h0,        32'h1,        4'd2},   // R2 lock 5
    {1'b0, 1'b0, 8'h04, 32'h0,        32'h00000020, 4'd6},
    {1'b0, 1'b0, 8'h04, 32'h0,        32'h00000020, 4'd6}    // R6 no side effect
  };

  task automatic chk(input int rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic drive(input logic core, input logic w, input logic [7:0] a, input logic [31:0] d);
    if (!core) begin c0_req = 1; c0_we = w; c0_addr = a; c0_wdata = d; end
    else       begin c1_req = 1; c1_we = w; c1_addr = a; c1_wdata = d; end
  endtask

  task automatic idle();
    c0_req = 0; c1_req = 0; c0_we = 0; c1_we = 0; clr_all = 0;
  endtask

  task automatic single(input logic core, input logic w, input logic [7:0] a,
                        input logic [31:0] d, input logic [31:0] exp, input int rq);
    drive(core, w, a, d);
    @(negedge clk);
    chk(12, {31'b0, core ? c1_ready : c0_ready}, 32'h1);
    chk(rq, core ? c1_rdata : c0_rdata, exp);
    idle();
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(8, {30'b0, c1_ready, c0_ready}, 32'h0);   // R8
    chk(8, c0_rdata | c1_rdata, 32'h0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      single(VEC[i][77], VEC[i][76], VEC[i][75:68], VEC[i][67:36], VEC[i][35:4], int'(VEC[i][3:0]));

    @(negedge clk);
    chk(12, {30'b0, c1_ready, c0_ready}, 32'h0);  // R12 idle

    // R10 both cores read free lock 7
    drive(0, 0, 8'h9C, 0); drive(1, 0, 8'h9C, 0);
    @(negedge clk);
    chk(10, c0_rdata, 32'h1);
    chk(10, c1_rdata, 32'h0);
    idle();

    // R11 core 0 frees lock 7 while core 1 reads it
    drive(0, 1, 8'h9C, 0); drive(1, 0, 8'h9C, 0);
    @(negedge clk);
    chk(11, c1_rdata, 32'h1);
    idle();
    single(0, 0, 8'h04, 0, 32'h000000A0, 11);

    // R6 status shows state before a same-cycle acquire of lock 2
    drive(0, 0, 8'h04, 0); drive(1, 0, 8'h88, 0);
    @(negedge clk);
    chk(6, c0_rdata, 32'h000000A0);
    chk(2, c1_rdata, 32'h1);
    idle();

    // R1 unaligned and unmapped addresses do nothing
    single(1, 0, 8'h81, 0, 32'h0, 1);
    single(1, 0, 8'h10, 0, 32'h0, 1);
    single(0, 0, 8'h04, 0, 32'h000000A4, 1);

    // R9 clear everything; a same-cycle read of lock 3 fails
    clr_all = 1; drive(0, 0, 8'h8C, 0);
    @(negedge clk);
    chk(9, c0_rdata, 32'h0);
    idle();
    single(1, 0, 8'h04, 0, 32'h0, 9);

    // R8 reset mid-run
    single(0, 0, 8'h84, 0, 32'h1, 2);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    single(0, 0, 8'h04, 0, 32'h0, 8);
    single(1, 0, 8'h84, 0, 32'h1, 8);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule